// File: doc/BRIEF.md
# Power-Management Command Port with SMI Trigger

This block sits behind a host-writable command byte used by firmware and the operating system to change power-management mode. Two reserved command codes act as a mode switch. One sets the SCI-enable flag, which routes power events to the operating system instead of firmware. The other clears that flag. Neither of them interrupts anything. Every other command code is a request for a system-management interrupt (SMI). The SMI is raised only if a gate bit in the block's local configuration bytes is set.

The block keeps a bank of four configuration bytes that can be read and written one byte at a time, at offsets 0x58 through 0x5B. It also holds the last command byte written, so that an SMI handler can find out which code woke it. The SMI request is a level output. It stays asserted until the handler pulses the acknowledge input. When the block is built without system-management-mode support, the gate byte comes out of reset already holding 0x02. This marks the mode as initialised.

Top module: `pmcmd_smi_port`

## Requirements
- R1: A command write of 0xF1 sets `sci_en` on the clock edge that takes the write, and it raises no SMI.
- R2: A command write of 0xF0 clears `sci_en` on the clock edge that takes the write, and it raises no SMI.
- R3: The codes 0xF0 and 0xF1 never assert `smi_req`, whatever the gate bit holds.
- R4: A command write of any other code asserts `smi_req` on the next edge exactly when bit 1 of configuration byte 0x5B is set. Such a write never changes `sci_en`, and the other bits of byte 0x5B have no effect on the gate.
- R5: After reset, configuration bytes 0x58, 0x59, 0x5A and 0x5B read 0x00, and `sci_en`, `smi_req` and `cmd_status` are all 0. This holds with `SMM_PRESENT`=1.
- R6: With `SMM_PRESENT`=0, byte 0x5B reads 0x02 after reset, and the other three bytes read 0x00.
- R7: Once asserted, `smi_req` stays high until a one-cycle `smi_ack` pulse clears it on the next edge. Further qualifying writes while the request is pending leave it high.
- R8: If a qualifying command write and `smi_ack` occur in the same cycle, `smi_req` is high after that edge. An acknowledge paired with a reserved code (0xF0 or 0xF1) still clears the request.
- R9: `cmd_status` holds the most recent command byte written, reserved codes included, from the edge after the write.
- R10: Configuration writes to offsets 0x58 to 0x5B change only the addressed byte. Writes to any other offset change nothing. Reads of any other offset return 0x00 on the combinational `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte write strobe, one cycle per write |
| cmd_data | input | 8 | Command byte |
| smi_ack | input | 1 | Handler acknowledge that clears the SMI request |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr`, combinational |
| cmd_status | output | 8 | Last command byte written |
| sci_en | output | 1 | SCI-enable state |
| smi_req | output | 1 | Level SMI request |

## Verification
On every cycle, the checker confirms the following. The two reserved codes drive `sci_en` to their fixed values and never start an SMI. A gated code starts an SMI, and an ungated code does not. `sci_en` moves only on a reserved code. The request holds until an acknowledge, and a qualifying write wins over an acknowledge in the same cycle. The status byte follows the last write. Only the directed scenarios can show the rest. These are the reset contents of the byte bank in both build variants, byte isolation and zero reads outside the window, the fact that only bit 1 of the gate byte matters, and the way the acknowledge behaves when paired with a reserved code.

// File: rtl/pmcmd_pkg.sv
package pmcmd_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE    = 2'd0,
      CMD_SCI_ON  = 2'd1,
      CMD_SCI_OFF = 2'd2,
      CMD_TRAP    = 2'd3
   } cmd_kind_e;

   function automatic cmd_kind_e classify_cmd(
      input logic       wr,
      input logic [7:0] code,
      input logic [7:0] on_code,
      input logic [7:0] off_code
   );
      if (!wr)                  return CMD_IDLE;
      else if (code == on_code)  return CMD_SCI_ON;
      else if (code == off_code) return CMD_SCI_OFF;
      else                       return CMD_TRAP;
   endfunction

endpackage

// File: rtl/pmcmd_cfg_bank.sv
module pmcmd_cfg_bank #(
   parameter int DW          = 8,
   parameter int AW          = 8,
   parameter int BASE        = 'h58,
   parameter int NBYTES      = 4,
   parameter bit SMM_PRESENT = 1'b1,
   parameter int GATE_IDX    = 3,
   parameter int GATE_BIT    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          gate
);
   localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   if (NBYTES < 1 || GATE_IDX >= NBYTES)
      $error("pmcmd_cfg_bank: gate byte outside bank");
   if (GATE_BIT >= DW)
      $error("pmcmd_cfg_bank: gate bit outside byte");
   if (BASE + NBYTES > (1 << AW))
      $error("pmcmd_cfg_bank: window exceeds address space");

   logic [DW-1:0] bytes_q [NBYTES];
   logic [AW-1:0] off;
   logic          hit;
   logic [IW-1:0] idx;

   always_comb begin
      off = cfg_off(addr);
      hit = (addr >= AW'(BASE)) && (off < AW'(NBYTES));
      idx = off[IW-1:0];
   end

   function automatic logic [AW-1:0] cfg_off(input logic [AW-1:0] a);
      return a - AW'(BASE);
   endfunction

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam logic [DW-1:0] RST_VAL =
         (i == GATE_IDX && !SMM_PRESENT) ? DW'(1 << GATE_BIT) : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bytes_q[i] <= RST_VAL;
         else if (wr && hit && idx == IW'(i))
            bytes_q[i] <= wdata;
      end
   end

   assign rdata = hit ? bytes_q[idx] : '0;
   assign gate  = bytes_q[GATE_IDX][GATE_BIT];

endmodule

// File: rtl/pmcmd_smi_latch.sv
module pmcmd_smi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic trap,
   input  logic gate,
   input  logic ack,
   output logic req
);
   logic set_req;

   assign set_req = trap && gate;

   always_ff @(posedge clk) begin
      if (!rst_n)       req <= 1'b0;
      else if (set_req) req <= 1'b1;
      else if (ack)     req <= 1'b0;
   end

endmodule

// File: rtl/pmcmd_smi_port.sv
module pmcmd_smi_port #(
   parameter int         DW          = 8,
   parameter int         AW          = 8,
   parameter int         CFG_BASE    = 'h58,
   parameter int         CFG_BYTES   = 4,
   parameter int         GATE_IDX    = 3,
   parameter int         GATE_BIT    = 1,
   parameter bit         SMM_PRESENT = 1'b1,
   parameter logic [7:0] SCI_ON_CODE  = 8'hF1,
   parameter logic [7:0] SCI_OFF_CODE = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [7:0]    cmd_data,
   input  logic          smi_ack,
   input  logic [AW-1:0] cfg_addr,
   input  logic          cfg_wr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   output logic [7:0]    cmd_status,
   output logic          sci_en,
   output logic          smi_req
);
   import pmcmd_pkg::*;

   if (SCI_ON_CODE == SCI_OFF_CODE)
      $error("pmcmd_smi_port: reserved codes must differ");

   cmd_kind_e kind;
   logic      smi_gate;

   assign kind = classify_cmd(cmd_wr, cmd_data, SCI_ON_CODE, SCI_OFF_CODE);

   pmcmd_cfg_bank #(
      .DW(DW), .AW(AW), .BASE(CFG_BASE), .NBYTES(CFG_BYTES),
      .SMM_PRESENT(SMM_PRESENT), .GATE_IDX(GATE_IDX), .GATE_BIT(GATE_BIT)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .wr(cfg_wr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .gate(smi_gate)
   );

   pmcmd_smi_latch u_smi (
      .clk(clk), .rst_n(rst_n), .trap(kind == CMD_TRAP),
      .gate(smi_gate), .ack(smi_ack), .req(smi_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sci_en     <= 1'b0;
         cmd_status <= 8'h00;
      end else begin
         if (cmd_wr)              cmd_status <= cmd_data;
         if (kind == CMD_SCI_ON)  sci_en <= 1'b1;
         if (kind == CMD_SCI_OFF) sci_en <= 1'b0;
      end
   end

endmodule

// File: rtl/pmcmd_smi_port_chk.sv
module pmcmd_smi_port_chk #(
   parameter logic [7:0] ON_CODE  = 8'hF1,
   parameter logic [7:0] OFF_CODE = 8'hF0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic [7:0] cmd_data,
   input logic       smi_ack,
   input logic       gate,
   input logic       sci_en,
   input logic       smi_req,
   input logic [7:0] cmd_status
);
   logic rsv;
   assign rsv = (cmd_data == ON_CODE) || (cmd_data == OFF_CODE);

   a_r1_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_data == ON_CODE |=> sci_en);

   a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_data == OFF_CODE |=> !sci_en);

   a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && rsv && !smi_req |=> !smi_req);

   a_r4_gated_raise: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && !rsv && gate |=> smi_req);

   a_r4_ungated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && !rsv && !gate && !smi_req |=> !smi_req);

   a_r4_sci_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_wr && rsv) |=> $stable(sci_en));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req && !smi_ack |=> smi_req);

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      smi_ack && !(cmd_wr && !rsv && gate) |=> !smi_req);

   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      smi_ack && cmd_wr && !rsv && gate |=> smi_req);

   a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> cmd_status == $past(cmd_data));

endmodule

bind pmcmd_smi_port pmcmd_smi_port_chk #(
   .ON_CODE(SCI_ON_CODE), .OFF_CODE(SCI_OFF_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
   .smi_ack(smi_ack), .gate(smi_gate), .sci_en(sci_en),
   .smi_req(smi_req), .cmd_status(cmd_status)
);

// File: tb/pmcmd_smi_port_test.sv
module pmcmd_smi_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_data = 8'h00;
   logic       smi_ack = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata, cmd_status, lg_rdata, lg_status;
   logic       sci_en, smi_req, lg_sci, lg_smi;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pmcmd_smi_port uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .smi_ack(smi_ack), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_status(cmd_status),
      .sci_en(sci_en), .smi_req(smi_req)
   );

   pmcmd_smi_port #(.SMM_PRESENT(1'b0)) uut_legacy (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .smi_ack(smi_ack), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(lg_rdata), .cmd_status(lg_status),
      .sci_en(lg_sci), .smi_req(lg_smi)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] d, input logic ack);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_data = d; smi_ack = ack;
      @(negedge clk);
      cmd_wr = 1'b0; smi_ack = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk); smi_ack = 1'b1;
      @(negedge clk); smi_ack = 1'b0;
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [7:0] d, output logic [7:0] ld);
      @(negedge clk);
      cfg_addr = a;
      #1;
      d = cfg_rdata; ld = lg_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d, ld;
      check("R5 sci_en", sci_en, 0);
      check("R5 smi_req", smi_req, 0);
      check("R5 cmd_status", cmd_status, 0);
      for (int a = 'h58; a <= 'h5B; a++) begin
         cfg_read(8'(a), d, ld);
         check("R5 cfg byte", d, 0);
         check("R6 legacy cfg byte", ld, (a == 'h5B) ? 8'h02 : 8'h00);
      end
   endtask

   task automatic t_legacy_gate();
      cmd(8'h42, 1'b0);
      check("R6 legacy preset gate raises SMI", lg_smi, 1);
      check("R4 ungated uut no SMI", smi_req, 0);
      ack_pulse();
      check("R7 legacy ack clears", lg_smi, 0);
   endtask

   task automatic t_cfg();
      logic [7:0] d, ld;
      cfg_write(8'h58, 8'hA5);
      cfg_write(8'h59, 8'h3C);
      cfg_write(8'h5A, 8'hFF);
      cfg_write(8'h57, 8'h77);
      cfg_write(8'h5C, 8'h88);
      cfg_read(8'h58, d, ld); check("R10 byte 58", d, 8'hA5);
      cfg_read(8'h59, d, ld); check("R10 byte 59", d, 8'h3C);
      cfg_read(8'h5A, d, ld); check("R10 byte 5A", d, 8'hFF);
      cfg_read(8'h5B, d, ld); check("R10 byte 5B untouched", d, 8'h00);
      cfg_read(8'h57, d, ld); check("R10 read below window", d, 8'h00);
      cfg_read(8'h5C, d, ld); check("R10 read above window", d, 8'h00);
      cfg_read(8'h00, d, ld); check("R10 read offset 0", d, 8'h00);
   endtask

   task automatic t_acpi();
      cmd(8'hF1, 1'b0);
      check("R1 sci_en set", sci_en, 1);
      check("R1 no SMI", smi_req, 0);
      check("R9 status F1", cmd_status, 8'hF1);
      cmd(8'hF0, 1'b0);
      check("R2 sci_en clear", sci_en, 0);
      check("R9 status F0", cmd_status, 8'hF0);
      cfg_write(8'h5B, 8'h02);
      cmd(8'hF1, 1'b0);
      check("R3 F1 gated no SMI", smi_req, 0);
      cmd(8'hF0, 1'b0);
      check("R3 F0 gated no SMI", smi_req, 0);
      check("R2 sci_en clear again", sci_en, 0);
   endtask

   task automatic t_trap();
      cfg_write(8'h5B, 8'hFD);
      cmd(8'hF1, 1'b0);
      cmd(8'h42, 1'b0);
      check("R4 bit1 clear no SMI", smi_req, 0);
      check("R4 sci_en untouched", sci_en, 1);
      check("R9 status 42", cmd_status, 8'h42);
      cfg_write(8'h5B, 8'h02);
      cmd(8'h13, 1'b0);
      check("R4 gated SMI", smi_req, 1);
      check("R4 sci_en still set", sci_en, 1);
   endtask

   task automatic t_hold();
      repeat (3) @(negedge clk);
      check("R7 held while idle", smi_req, 1);
      cmd(8'h55, 1'b0);
      check("R7 held on new write", smi_req, 1);
      check("R9 status 55", cmd_status, 8'h55);
      ack_pulse();
      check("R7 ack clears", smi_req, 0);
      ack_pulse();
      check("R7 ack idle stays low", smi_req, 0);
   endtask

   task automatic t_collide();
      cmd(8'h77, 1'b1);
      check("R8 write wins over ack", smi_req, 1);
      cmd(8'hF0, 1'b1);
      check("R8 reserved code with ack clears", smi_req, 0);
      check("R2 sci_en cleared in collision", sci_en, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_legacy_gate();
      t_cfg();
      t_acpi();
      t_trap();
      t_hold();
      t_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule